// File: doc/BRIEF.md
# Mode-Selectable Four-Beat Burst Address Counter

This block generates the address sequence for a four-beat burst. When a burst starts, it registers the full start address. The upper bits are then presented unchanged for the whole burst. The two low bits come from a small counter, which steps on every cycle in which the advance input is high.

The order of the low bits is set by a mode input. Mode low gives the linear order: the low bits go up by one on each beat and wrap modulo four. Mode high gives the interleaved order: the low bits equal the start bits XORed with a beat index that runs 00, 01, 10, 11. Both orders return to the start address after four beats.

The mode input is sampled only when a burst is loaded. A board or parent design that has no use for the choice should tie it high, which gives the interleaved order, the default for this block. The output is registered and shows the new value in the cycle after the load or advance edge.

Top module: `burst_addr_ctr`

## Requirements
- R1: A cycle with `load` high makes `addr_out` equal the whole `start_addr` in the next cycle. Bits above bit 1 then stay unchanged until the next load.
- R2: With mode 0 latched at load, each advance adds one to `addr_out[1:0]` modulo four, so a start of 10 gives 10, 11, 00, 01.
- R3: With mode 1 latched at load, beat k shows start XOR k, so a start of 01 gives 01, 00, 11, 10 and a start of 10 gives 10, 11, 00, 01.
- R4: A cycle with `load` and `advance` both low leaves `addr_out` unchanged.
- R5: The fifth address of a burst, after four advances, equals the first.
- R6: `load` takes priority over `advance`. When both are high, the burst restarts from the new `start_addr`.
- R7: While `rst_n` is low, and after it is released, `addr_out` is all zeros until the first load.
- R8: A change of `mode` between loads has no effect on the current burst's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Start a new burst from `start_addr` |
| start_addr | input | ADDR_W | Burst start address |
| advance | input | 1 | Step to the next beat |
| mode | input | 1 | 0 linear, 1 interleaved (tie high by default); sampled at load |
| addr_out | output | ADDR_W | Current burst address |

## Verification
Several properties are checked on every cycle: the load seeds the output, an idle cycle holds it, the upper bits stay put between loads, and the latched mode stays fixed between loads. Each single step is also checked against the order chosen at load: plus one for linear, and a change equal to the change in the beat index for interleaved. Complete sequences for every start value in both modes, the wrap back to the first address after four beats, load winning over advance, and the reset value are shown only by the bench's scenarios.

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              advance,
  input  logic              mode,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] upper_q;
  logic [1:0]      start_q;
  logic [1:0]      beat_q;
  logic            mode_q;
  logic [1:0]      lo_lin;
  logic [1:0]      lo_ilv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= 2'b00;
      beat_q  <= 2'b00;
      mode_q  <= 1'b1;
    end else if (load) begin
      upper_q <= start_addr[ADDR_W-1:2];
      start_q <= start_addr[1:0];
      beat_q  <= 2'b00;
      mode_q  <= mode;
    end else if (advance) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign lo_lin   = start_q + beat_q;
  assign lo_ilv   = start_q ^ beat_q;
  assign addr_out = {upper_q, (mode_q ? lo_ilv : lo_lin)};
endmodule

module burst_addr_ctr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [ADDR_W-1:0] start_addr,
  input logic              advance,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat_q,
  input logic              mode_q
);
  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n) load |=> addr_out == $past(start_addr)); // R1
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R1
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!load && advance && !mode_q) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R2
  AST_INTLV_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!load && advance && mode_q) |=> (addr_out[1:0] ^ $past(addr_out[1:0])) == ($past(beat_q) ^ ($past(beat_q) + 2'd1))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!load && !advance) |=> $stable(addr_out)); // R4
  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(mode_q)); // R8
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
  .advance(advance), .addr_out(addr_out), .beat_q(beat_q), .mode_q(mode_q)
);

// File: tb/tb_burst_addr_ctr.sv
`timescale 1ns/100ps
module tb_burst_addr_ctr;
  localparam int ADDR_W = 8;
  localparam int NVEC = 8;
  // {mode, start_lo, expected beats b0 b1 b2 b3 packed high to low}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 8'h1B}, {1'b0, 2'd1, 8'h6C}, {1'b0, 2'd2, 8'hB1}, {1'b0, 2'd3, 8'hC6},
    {1'b1, 2'd0, 8'h1B}, {1'b1, 2'd1, 8'h4E}, {1'b1, 2'd2, 8'hB1}, {1'b1, 2'd3, 8'hE4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic advance = 1'b0;
  logic mode = 1'b1;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [ADDR_W-1:0] addr_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .advance(advance), .mode(mode), .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] up;
    @(negedge clk);
    check("R7", '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", '0);

    for (int v = 0; v < NVEC; v++) begin
      up = ADDR_W'((v * 37 + 5) << 2);
      load = 1'b1; mode = VEC[v][10]; start_addr = up | ADDR_W'(VEC[v][9:8]);
      @(negedge clk);
      load = 1'b0; mode = ~VEC[v][10]; advance = 1'b1; start_addr = ~start_addr;
      check("R1", up | ADDR_W'(VEC[v][7:6]));
      for (int b = 1; b < 4; b++) begin
        @(negedge clk);
        check(VEC[v][10] ? "R3 R8" : "R2 R8", up | ADDR_W'(VEC[v][7-2*b -: 2]));
      end
      @(negedge clk);
      advance = 1'b0;
      check("R5", up | ADDR_W'(VEC[v][7:6]));
      @(negedge clk);
    end

    load = 1'b1; mode = 1'b0; start_addr = 8'hA6;
    @(negedge clk);
    load = 1'b0;
    check("R1", 8'hA6);
    repeat (3) @(negedge clk);
    check("R4", 8'hA6);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R2", 8'hA7);
    @(negedge clk);
    check("R4", 8'hA7);

    load = 1'b1; advance = 1'b1; mode = 1'b1; start_addr = 8'h35;
    @(negedge clk);
    load = 1'b0;
    check("R6", 8'h35);
    @(negedge clk);
    advance = 1'b0;
    check("R3", 8'h34);

    rst_n = 1'b0;
    @(negedge clk);
    check("R7", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule